// File: doc/BRIEF.md
# Drive Status and Host Interrupt Controller

This block owns the eight-bit status byte that a disk drive presents to its host, and the host interrupt line. The command engine beside it reports when a command is written, when it finishes, when an error or a corrected-data event occurs, and when data words arrive during a write. The block combines these events with the live drive conditions (ready, write fault, seek settled, index) to build the status byte. It also decides when an interrupt is pending and whether the interrupt pin may be driven.

Host register decoding is done elsewhere. This block only sees strobes: a primary status read, an alternate status read, and a device-control write with its data byte. A primary status read acknowledges the interrupt. An alternate read returns the same byte and leaves the interrupt alone. After an error, the ready, write-fault and seek bits keep their values until the host acknowledges with a primary read.

A software reset bit in device control holds the drive in reset. While reset is active, and for a parameterised settle time after reset ends, the status byte reads busy only.

Top module: `drv_status_ctrl`

## Requirements
- R1: While `rst_n` is low, and after the last clock edge at which reset (hardware or software) is still active, `status_o` reads 8'h80 until the POST_RST_CYCLES-th following edge. At that edge BSY clears. No interrupt is pending after a reset.
- R2: Status bit 7 is BSY. While BSY is 1 the byte reads exactly 8'h80. Otherwise bits 6 to 0 are, from high to low: ready, write fault, seek complete, data request (`drq_i`, live), corrected, index, error.
- R3: A command write with `cmd_busy_kind_i`=1 sets BSY at the next edge. `done_i` clears BSY.
- R4: During a command started with `cmd_busy_kind_i`=0, the BLOCK_WORDS-th data word written while BSY=0 sets BSY. Data words written while BSY=1 are not counted.
- R5: `done_i` makes the interrupt pending. A primary status read clears it. When both happen in the same cycle, pending wins.
- R6: An alternate status read neither clears the pending interrupt nor unfreezes the condition bits.
- R7: `intrq_oe_o` = `sel_i` AND NOT device-control bit 1 (interrupt disable). `intrq_o` is the pending flag gated by `intrq_oe_o`.
- R8: Writing device control with bit 2 set asserts `srst_hold_o` and forces 8'h80 from the next edge. It clears the pending interrupt, the error bit and the corrected bit. Writing bit 2 clear starts the R1 settle time.
- R9: An `err_i` pulse during a command sets the error bit when `done_i` arrives. At that edge ready, write fault and seek complete freeze until a primary status read, and then track their inputs again. The next command write clears the error bit.
- R10: The index bit is 1 for exactly one cycle after each rising edge of `index_i`.
- R11: The corrected bit is set by `corr_i` and stays set until the next command write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel_i | input | 1 | This drive is the selected one |
| cmd_wr_i | input | 1 | Host wrote the command register |
| cmd_busy_kind_i | input | 1 | Written command goes busy at once (non-data-out kind) |
| data_wr_i | input | 1 | Host wrote one data word |
| done_i | input | 1 | Command engine finished the command or block |
| err_i | input | 1 | Error event during the current command |
| corr_i | input | 1 | Corrected data event |
| drq_i | input | 1 | Data request from the command engine |
| rdy_i | input | 1 | Live drive-ready condition |
| wflt_i | input | 1 | Live write-fault condition |
| seek_ok_i | input | 1 | Live seek-complete condition |
| index_i | input | 1 | Index sensor level |
| stat_rd_i | input | 1 | Host read of primary status |
| alt_rd_i | input | 1 | Host read of alternate status |
| ctl_wr_i | input | 1 | Host write of device control |
| ctl_data_i | input | 8 | Device control data byte |
| status_o | output | 8 | Status byte |
| intrq_o | output | 1 | Interrupt request value |
| intrq_oe_o | output | 1 | Interrupt pin drive enable (low means high impedance) |
| srst_hold_o | output | 1 | Software reset hold |

## Verification
The bench builds the block with POST_RST_CYCLES=3 and BLOCK_WORDS=4. With these values the settle time after hardware and software reset can be counted edge by edge, and a full write block wraps within a few words. That makes it possible to check the last-word busy transition, and to check that a word written while busy is not counted, on the very next block. The deployed defaults (a long settle time, 256-word blocks) exercise the same counters, only longer.

// File: rtl/drv_stat_pkg.sv
package drv_stat_pkg;

  localparam int unsigned ST_W = 8;

  // status byte bit positions (host decodes these)
  localparam int unsigned ST_BSY  = 7;
  localparam int unsigned ST_DRDY = 6;
  localparam int unsigned ST_DWF  = 5;
  localparam int unsigned ST_DSC  = 4;
  localparam int unsigned ST_DRQ  = 3;
  localparam int unsigned ST_CORR = 2;
  localparam int unsigned ST_IDX  = 1;
  localparam int unsigned ST_ERR  = 0;

  // device control bit positions
  localparam int unsigned CTL_SRST = 2;
  localparam int unsigned CTL_NIEN = 1;

  typedef struct packed {
    logic rdy;
    logic wflt;
    logic seek;
  } cond_t;

  function automatic logic [ST_W-1:0] pack_status(
    input logic  bsy,
    input cond_t c,
    input logic  drq,
    input logic  corr,
    input logic  idx,
    input logic  err
  );
    logic [ST_W-1:0] s;
    s = '0;
    if (bsy) begin
      s[ST_BSY] = 1'b1;
    end else begin
      s[ST_DRDY] = c.rdy;
      s[ST_DWF]  = c.wflt;
      s[ST_DSC]  = c.seek;
      s[ST_DRQ]  = drq;
      s[ST_CORR] = corr;
      s[ST_IDX]  = idx;
      s[ST_ERR]  = err;
    end
    return s;
  endfunction

endpackage

// File: rtl/stat_busy_ctrl.sv
module stat_busy_ctrl #(
  parameter int unsigned POST_RST_CYCLES = 1000,
  parameter int unsigned BLOCK_WORDS     = 256
) (
  input  logic clk,
  input  logic rst_n,
  input  logic srst_i,
  input  logic cmd_wr_i,
  input  logic cmd_busy_kind_i,
  input  logic data_wr_i,
  input  logic done_i,
  output logic bsy_o,
  output logic rst_phase_o
);

  localparam int unsigned CW = (POST_RST_CYCLES > 1) ? $clog2(POST_RST_CYCLES) : 1;
  localparam int unsigned WW = (BLOCK_WORDS > 1) ? $clog2(BLOCK_WORDS) : 1;
  localparam logic [CW-1:0] RLOAD = CW'(POST_RST_CYCLES - 1);
  localparam logic [WW-1:0] WLAST = WW'(BLOCK_WORDS - 1);

  logic          bsy_q, bsy_n;
  logic          rb_q, rb_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic [WW-1:0] wc_q, wc_n;
  logic          en;

  assign en = srst_i | rb_q | cmd_wr_i | data_wr_i | done_i;

  always_comb begin
    bsy_n = bsy_q;
    rb_n  = rb_q;
    cnt_n = cnt_q;
    wc_n  = wc_q;
    if (srst_i) begin
      bsy_n = 1'b1;
      rb_n  = 1'b1;
      cnt_n = RLOAD;
      wc_n  = '0;
    end else if (rb_q) begin
      if (cnt_q == '0) begin
        bsy_n = 1'b0;
        rb_n  = 1'b0;
      end else begin
        cnt_n = cnt_q - 1'b1;
      end
    end else if (cmd_wr_i) begin
      wc_n = '0;
      if (cmd_busy_kind_i) bsy_n = 1'b1;
    end else if (data_wr_i && !bsy_q) begin
      if (wc_q == WLAST) begin
        wc_n  = '0;
        bsy_n = 1'b1;
      end else begin
        wc_n = wc_q + 1'b1;
      end
    end else if (done_i) begin
      bsy_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bsy_q <= 1'b1;
      rb_q  <= 1'b1;
      cnt_q <= RLOAD;
      wc_q  <= '0;
    end else if (en) begin
      bsy_q <= bsy_n;
      rb_q  <= rb_n;
      cnt_q <= cnt_n;
      wc_q  <= wc_n;
    end
  end

  assign bsy_o       = bsy_q;
  assign rst_phase_o = rb_q;

endmodule

// File: rtl/stat_cond_hold.sv
module stat_cond_hold
  import drv_stat_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  srst_i,
  input  logic  cmd_wr_i,
  input  logic  done_i,
  input  logic  err_i,
  input  logic  corr_i,
  input  logic  index_i,
  input  logic  stat_rd_i,
  input  cond_t live_i,
  output cond_t cond_o,
  output logic  err_o,
  output logic  corr_o,
  output logic  idx_o,
  output logic  frozen_o
);

  logic  epend_q, epend_n;
  logic  err_q, err_n;
  logic  corr_q, corr_n;
  logic  frz_q, frz_n;
  cond_t snap_q, snap_n;
  logic  idx_s_q, idx_p_q;
  logic  ev_en, err_hit;

  assign err_hit = epend_q | err_i;
  assign ev_en   = srst_i | cmd_wr_i | done_i | err_i | corr_i | stat_rd_i;

  always_comb begin
    epend_n = epend_q;
    err_n   = err_q;
    corr_n  = corr_q;
    frz_n   = frz_q;
    snap_n  = snap_q;
    if (srst_i) begin
      epend_n = 1'b0;
      err_n   = 1'b0;
      corr_n  = 1'b0;
      frz_n   = 1'b0;
    end else begin
      if (cmd_wr_i) begin
        epend_n = err_i;
        err_n   = 1'b0;
        corr_n  = corr_i;
      end else begin
        corr_n = corr_q | corr_i;
        if (done_i) begin
          epend_n = 1'b0;
          err_n   = err_hit;
        end else begin
          epend_n = err_hit;
        end
      end
      if (done_i && !cmd_wr_i && err_hit && !frz_q) begin
        frz_n  = 1'b1;
        snap_n = live_i;
      end else if (stat_rd_i) begin
        frz_n = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      epend_q <= 1'b0;
      err_q   <= 1'b0;
      corr_q  <= 1'b0;
      frz_q   <= 1'b0;
      snap_q  <= '0;
    end else if (ev_en) begin
      epend_q <= epend_n;
      err_q   <= err_n;
      corr_q  <= corr_n;
      frz_q   <= frz_n;
      snap_q  <= snap_n;
    end
  end

  // index edge detector: one-cycle pulse per rising edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_s_q <= 1'b0;
      idx_p_q <= 1'b0;
    end else begin
      idx_s_q <= index_i;
      idx_p_q <= index_i & ~idx_s_q;
    end
  end

  assign cond_o   = frz_q ? snap_q : live_i;
  assign err_o    = err_q;
  assign corr_o   = corr_q;
  assign idx_o    = idx_p_q;
  assign frozen_o = frz_q;

endmodule

// File: rtl/stat_irq_ctrl.sv
module stat_irq_ctrl
  import drv_stat_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            ctl_wr_i,
  input  logic [ST_W-1:0] ctl_data_i,
  input  logic            done_i,
  input  logic            stat_rd_i,
  output logic            srst_now_o,
  output logic            srst_o,
  output logic            pend_o,
  output logic            intrq_o,
  output logic            intrq_oe_o
);

  logic srst_q, nien_q;
  logic pend_q, pend_n;
  logic srst_now;
  logic unused_ctl;

  assign unused_ctl = ^{ctl_data_i[ST_W-1:CTL_SRST+1], ctl_data_i[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst_q <= 1'b0;
      nien_q <= 1'b0;
    end else if (ctl_wr_i) begin
      srst_q <= ctl_data_i[CTL_SRST];
      nien_q <= ctl_data_i[CTL_NIEN];
    end
  end

  assign srst_now = srst_q | (ctl_wr_i & ctl_data_i[CTL_SRST]);

  always_comb begin
    pend_n = pend_q;
    if (srst_now)       pend_n = 1'b0;
    else if (done_i)    pend_n = 1'b1;
    else if (stat_rd_i) pend_n = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_n;
  end

  assign srst_now_o = srst_now;
  assign srst_o     = srst_q;
  assign pend_o     = pend_q;
  assign intrq_oe_o = sel_i & ~nien_q;
  assign intrq_o    = pend_q & intrq_oe_o;

endmodule

// File: rtl/drv_status_ctrl.sv
module drv_status_ctrl
  import drv_stat_pkg::*;
#(
  parameter int unsigned POST_RST_CYCLES = 1000,
  parameter int unsigned BLOCK_WORDS     = 256
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            sel_i,
  input  logic            cmd_wr_i,
  input  logic            cmd_busy_kind_i,
  input  logic            data_wr_i,
  input  logic            done_i,
  input  logic            err_i,
  input  logic            corr_i,
  input  logic            drq_i,
  input  logic            rdy_i,
  input  logic            wflt_i,
  input  logic            seek_ok_i,
  input  logic            index_i,
  input  logic            stat_rd_i,
  input  logic            alt_rd_i,
  input  logic            ctl_wr_i,
  input  logic [ST_W-1:0] ctl_data_i,
  output logic [ST_W-1:0] status_o,
  output logic            intrq_o,
  output logic            intrq_oe_o,
  output logic            srst_hold_o
);

  logic  srst_now, bsy, rst_phase;
  logic  irq_pend, frozen;
  logic  err_b, corr_b, idx_b;
  cond_t live, cond_view;
  logic  unused_alt;

  // alternate reads return the same byte and change nothing
  assign unused_alt = alt_rd_i;

  assign live = '{rdy: rdy_i, wflt: wflt_i, seek: seek_ok_i};

  stat_irq_ctrl u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .sel_i      (sel_i),
    .ctl_wr_i   (ctl_wr_i),
    .ctl_data_i (ctl_data_i),
    .done_i     (done_i),
    .stat_rd_i  (stat_rd_i),
    .srst_now_o (srst_now),
    .srst_o     (srst_hold_o),
    .pend_o     (irq_pend),
    .intrq_o    (intrq_o),
    .intrq_oe_o (intrq_oe_o)
  );

  stat_busy_ctrl #(
    .POST_RST_CYCLES (POST_RST_CYCLES),
    .BLOCK_WORDS     (BLOCK_WORDS)
  ) u_busy (
    .clk             (clk),
    .rst_n           (rst_n),
    .srst_i          (srst_now),
    .cmd_wr_i        (cmd_wr_i),
    .cmd_busy_kind_i (cmd_busy_kind_i),
    .data_wr_i       (data_wr_i),
    .done_i          (done_i),
    .bsy_o           (bsy),
    .rst_phase_o     (rst_phase)
  );

  stat_cond_hold u_cond (
    .clk       (clk),
    .rst_n     (rst_n),
    .srst_i    (srst_now),
    .cmd_wr_i  (cmd_wr_i),
    .done_i    (done_i),
    .err_i     (err_i),
    .corr_i    (corr_i),
    .index_i   (index_i),
    .stat_rd_i (stat_rd_i),
    .live_i    (live),
    .cond_o    (cond_view),
    .err_o     (err_b),
    .corr_o    (corr_b),
    .idx_o     (idx_b),
    .frozen_o  (frozen)
  );

  assign status_o = pack_status(bsy, cond_view, drq_i, corr_b, idx_b, err_b);

endmodule

// File: rtl/drv_status_chk.sv
module drv_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr_i,
  input logic       cmd_busy_kind_i,
  input logic       done_i,
  input logic       stat_rd_i,
  input logic       alt_rd_i,
  input logic [7:0] status_o,
  input logic       intrq_o,
  input logic       intrq_oe_o,
  input logic       srst_hold_o,
  input logic       irq_pend,
  input logic       frozen,
  input logic       rst_phase,
  input logic [2:0] cond_view
);

  a_r5_done_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (done_i && !srst_hold_o && !$isunknown(done_i)) |=> (irq_pend || srst_hold_o));

  a_r5_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd_i && !done_i) |=> !irq_pend);

  a_r6_alt_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (alt_rd_i && !stat_rd_i && irq_pend && !srst_hold_o) |=> (irq_pend || srst_hold_o));

  a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
    intrq_o |-> intrq_oe_o);

  a_r8_srst_busy: assert property (@(posedge clk) disable iff (!rst_n)
    srst_hold_o |-> (status_o == 8'h80 && !intrq_o));

  a_r3_cmd_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_busy_kind_i && !rst_phase) |=> status_o[7]);

  a_r10_idx_single: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[1] |=> !status_o[1]);

  a_r9_frozen_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (frozen && !stat_rd_i && !srst_hold_o && !alt_rd_i) |=> $stable(cond_view) || !frozen);

  a_r2_busy_masks: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[7] |-> (status_o[6:0] == 7'd0));

endmodule

bind drv_status_ctrl drv_status_chk u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .cmd_wr_i        (cmd_wr_i),
  .cmd_busy_kind_i (cmd_busy_kind_i),
  .done_i          (done_i),
  .stat_rd_i       (stat_rd_i),
  .alt_rd_i        (alt_rd_i),
  .status_o        (status_o),
  .intrq_o         (intrq_o),
  .intrq_oe_o      (intrq_oe_o),
  .srst_hold_o     (srst_hold_o),
  .irq_pend        (irq_pend),
  .frozen          (frozen),
  .rst_phase       (rst_phase),
  .cond_view       (cond_view)
);

// File: tb/drv_status_ctrl_bench.sv
module drv_status_ctrl_bench;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       sel_i, cmd_wr_i, cmd_busy_kind_i, data_wr_i, done_i, err_i, corr_i;
  logic       drq_i, rdy_i, wflt_i, seek_ok_i, index_i, stat_rd_i, alt_rd_i, ctl_wr_i;
  logic [7:0] ctl_data_i;
  logic [7:0] status_o;
  logic       intrq_o, intrq_oe_o, srst_hold_o;

  int total = 0;
  int bad   = 0;
  bit finished = 0;

  typedef struct {
    string      tag;
    logic [7:0] st;
    logic       irq;
    logic       oe;
    logic       srst;
  } exp_t;

  exp_t exp_q[$];
  event mon_ev;

  always #2 clk = ~clk;

  drv_status_ctrl #(.POST_RST_CYCLES(3), .BLOCK_WORDS(4)) u_drv_status_ctrl (
    .clk(clk), .rst_n(rst_n), .sel_i(sel_i), .cmd_wr_i(cmd_wr_i),
    .cmd_busy_kind_i(cmd_busy_kind_i), .data_wr_i(data_wr_i), .done_i(done_i),
    .err_i(err_i), .corr_i(corr_i), .drq_i(drq_i), .rdy_i(rdy_i), .wflt_i(wflt_i),
    .seek_ok_i(seek_ok_i), .index_i(index_i), .stat_rd_i(stat_rd_i),
    .alt_rd_i(alt_rd_i), .ctl_wr_i(ctl_wr_i), .ctl_data_i(ctl_data_i),
    .status_o(status_o), .intrq_o(intrq_o), .intrq_oe_o(intrq_oe_o),
    .srst_hold_o(srst_hold_o)
  );

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(mon_ev);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        total++;
        if (status_o !== e.st || intrq_o !== e.irq || intrq_oe_o !== e.oe ||
            srst_hold_o !== e.srst) begin
          bad++;
          $display("FAIL %s: got st=%h irq=%b oe=%b srst=%b, want st=%h irq=%b oe=%b srst=%b",
                   e.tag, status_o, intrq_o, intrq_oe_o, srst_hold_o,
                   e.st, e.irq, e.oe, e.srst);
        end
      end
    end
  end

  task automatic push(string tag, logic [7:0] st, logic irq, logic oe, logic srst);
    exp_t e;
    e.tag = tag; e.st = st; e.irq = irq; e.oe = oe; e.srst = srst;
    exp_q.push_back(e);
    ->mon_ev;
  endtask

  // one clock: pulses set before the call act at this edge, then get cleared
  task automatic cyc(string tag, logic [7:0] st, logic irq, logic oe, logic srst);
    @(posedge clk);
    #1;
    push(tag, st, irq, oe, srst);
    @(negedge clk);
    cmd_wr_i = 0; cmd_busy_kind_i = 0; data_wr_i = 0; done_i = 0; err_i = 0;
    corr_i = 0; stat_rd_i = 0; alt_rd_i = 0; ctl_wr_i = 0; ctl_data_i = 8'h08;
  endtask

  task automatic ack();
    stat_rd_i = 1; cyc("ack", 8'h50, 0, 1, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: got hang, want completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sel_i = 1; cmd_wr_i = 0; cmd_busy_kind_i = 0; data_wr_i = 0;
    done_i = 0; err_i = 0; corr_i = 0; drq_i = 0; rdy_i = 1; wflt_i = 0;
    seek_ok_i = 1; index_i = 0; stat_rd_i = 0; alt_rd_i = 0; ctl_wr_i = 0;
    ctl_data_i = 8'h08;
    repeat (2) @(posedge clk);
    #1 push("R1 reset state", 8'h80, 0, 1, 0);
    @(negedge clk);
    rst_n = 1;
    cyc("R1 settle 1", 8'h80, 0, 1, 0);
    cyc("R1 settle 2", 8'h80, 0, 1, 0);
    cyc("R1 settle end", 8'h50, 0, 1, 0);

    // R3 / R5 / R6
    cmd_wr_i = 1; cmd_busy_kind_i = 1; cyc("R3 busy cmd", 8'h80, 0, 1, 0);
    done_i = 1;   cyc("R3 R5 done", 8'h50, 1, 1, 0);
    alt_rd_i = 1; cyc("R6 alt read keeps", 8'h50, 1, 1, 0);
    stat_rd_i = 1; cyc("R5 ack clears", 8'h50, 0, 1, 0);
    done_i = 1; stat_rd_i = 1; cyc("R5 done beats ack", 8'h50, 1, 1, 0);
    ack();

    // R7 enable gating
    ctl_wr_i = 1; ctl_data_i = 8'h0A; cyc("R7 disabled", 8'h50, 0, 0, 0);
    done_i = 1; cyc("R7 pending hidden", 8'h50, 0, 0, 0);
    ctl_wr_i = 1; ctl_data_i = 8'h08; cyc("R7 re-enabled", 8'h50, 1, 1, 0);
    sel_i = 0; cyc("R7 deselected", 8'h50, 0, 0, 0);
    sel_i = 1; stat_rd_i = 1; cyc("R7 R5 reselect ack", 8'h50, 0, 1, 0);

    // R2 live drq
    drq_i = 1; cyc("R2 drq bit", 8'h58, 0, 1, 0);
    drq_i = 0; cyc("R2 drq clear", 8'h50, 0, 1, 0);

    // R9 error freeze
    cmd_wr_i = 1; cmd_busy_kind_i = 1; cyc("R9 cmd", 8'h80, 0, 1, 0);
    err_i = 1; cyc("R9 err while busy", 8'h80, 0, 1, 0);
    done_i = 1; cyc("R9 done with err", 8'h51, 1, 1, 0);
    rdy_i = 0; wflt_i = 1; seek_ok_i = 0; cyc("R9 frozen", 8'h51, 1, 1, 0);
    alt_rd_i = 1; cyc("R9 R6 alt keeps freeze", 8'h51, 1, 1, 0);
    stat_rd_i = 1; cyc("R9 unfreeze on ack", 8'h21, 0, 1, 0);
    cmd_wr_i = 1; cyc("R9 err cleared by cmd", 8'h20, 0, 1, 0);
    rdy_i = 1; wflt_i = 0; seek_ok_i = 1; cyc("R9 live again", 8'h50, 0, 1, 0);

    // R4 write blocks
    cmd_wr_i = 1; cyc("R4 write cmd", 8'h50, 0, 1, 0);
    for (int i = 0; i < 3; i++) begin
      data_wr_i = 1; cyc("R4 word", 8'h50, 0, 1, 0);
    end
    data_wr_i = 1; cyc("R4 last word busy", 8'h80, 0, 1, 0);
    data_wr_i = 1; cyc("R4 word while busy", 8'h80, 0, 1, 0);
    done_i = 1; cyc("R4 block done", 8'h50, 1, 1, 0);
    ack();
    for (int i = 0; i < 3; i++) begin
      data_wr_i = 1; cyc("R4 ignored word not counted", 8'h50, 0, 1, 0);
    end
    data_wr_i = 1; cyc("R4 second block busy", 8'h80, 0, 1, 0);
    done_i = 1; cyc("R4 second done", 8'h50, 1, 1, 0);
    ack();

    // R10 index pulse
    index_i = 1; cyc("R10 idx pulse", 8'h52, 0, 1, 0);
    cyc("R10 idx one cycle", 8'h50, 0, 1, 0);
    index_i = 0; cyc("R10 idx low", 8'h50, 0, 1, 0);

    // R11 corrected
    corr_i = 1; cyc("R11 corr set", 8'h54, 0, 1, 0);
    cyc("R11 corr held", 8'h54, 0, 1, 0);
    cmd_wr_i = 1; cmd_busy_kind_i = 1; cyc("R11 cmd", 8'h80, 0, 1, 0);
    done_i = 1; cyc("R11 corr cleared", 8'h50, 1, 1, 0);

    // R8 / R1 software reset (interrupt still pending here)
    ctl_wr_i = 1; ctl_data_i = 8'h0C; cyc("R8 srst set", 8'h80, 0, 1, 1);
    cyc("R8 srst held", 8'h80, 0, 1, 1);
    ctl_wr_i = 1; ctl_data_i = 8'h08; cyc("R8 R1 srst release", 8'h80, 0, 1, 0);
    cyc("R1 srst settle 1", 8'h80, 0, 1, 0);
    cyc("R1 srst settle 2", 8'h80, 0, 1, 0);
    cyc("R1 srst settle end", 8'h50, 0, 1, 0);

    #1;
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule